// File: doc/BRIEF.md
# CPU Physical Address Window Decoder

This block holds a bank of programmable decode windows that steer CPU physical addresses (36 bits) to target devices. Every window has a control word carrying an enable bit, a 4-bit target code, an 8-bit attribute and a size mask, and a base word holding the window base. The lowest-numbered windows can also hold a remap base. On a hit, the remap base replaces the upper address bits of the outgoing address.

Software programs the windows through a 32-bit register port. The register space has two regions. The first region holds the first eight windows, with four words each. It is followed by a 16-byte gap. The second region holds the remaining windows, with two words each. The CPU side presents an address on the lookup port. One cycle later the block returns hit or decode error, the target, the attribute and the translated address. When more than one enabled window claims an address, the window with the lowest index wins.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled and all its registers read zero, so every lookup returns a decode error.
- R2: A control word reads back as enable in bit 0, target in bits 7:4, attribute in bits 15:8 and size mask in bits 31:16. Bits 3:1 read zero. The window covers (mask+1) × 64 KB.
- R3: A base word keeps address bits 31:16 in bits 31:16 and address bits 35:32 in bits 3:0. Bits 15:4 read zero.
- R4: Windows 0–7 sit at byte offset win×16, with the words in the order control (+0), base (+4), remap-low (+8), remap-high (+12). Offsets 0x80–0x8F are a gap. Windows 8 and above sit at 0x90+(win−8)×8, with control (+0) and base (+4). A gap offset, an offset beyond the last window, or an offset that is not a multiple of 4 reads zero and ignores writes.
- R5: Only windows with index below NUM_REMAP have remap words. On any other window those offsets read zero and ignore writes. Remap-low keeps bits 31:16 only, and its bits 15:0 read zero. Remap-high keeps all 32 bits.
- R6: An enabled window hits when lookup address bits 35:32 equal the stored base bits 35:32, and lookup bits 31:16 with the size-mask bits cleared equal the stored base bits 31:16.
- R7: A window whose enable bit is 0 never hits, whatever its other fields hold.
- R8: When several windows hit, the output target, attribute and translation come from the lowest-indexed one.
- R9: For a hitting window below NUM_REMAP, the translated address is built as follows: bits 35:32 come from remap-high bits 3:0; bits 31:16 are (remap-low AND NOT mask) OR (address AND mask); bits 15:0 are the address bits 15:0. For any other hitting window the translated address equals the lookup address.
- R10: A lookup is answered in the cycle after it is presented. On a hit, done=1, hit=1 and decode error=0. On a miss, done=1, hit=0, decode error=1, target and attribute are 0, and the translated address equals the lookup address. With no lookup presented, all lookup outputs are 0.
- R11: Read data appears in the cycle after a read request and holds its value until the next read. A write takes effect for a lookup presented in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_AW | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 36 | CPU physical address to decode |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Some enabled window matched |
| lk_decerr | output | 1 | No window matched |
| lk_target | output | 4 | Target code of the winning window |
| lk_attr | output | 8 | Attribute of the winning window |
| lk_xaddr | output | 36 | Translated address |

## Verification
The bench first uses directed layouts. Two windows overlap, which separates lowest-index priority from a plain first-match on any window. A disabled window sits over a probed address, which checks that the enable bit gates matching. A window with a matching low part but a different bits-35:32 value checks the upper-base compare. Random campaigns then program every window with random fields, size masks, enables and remap values. They probe addresses drawn inside chosen windows, so both remapped and pass-through translation are exercised, and mix in fully random addresses that mostly miss. Register accesses include the gap, the region boundary, misaligned offsets and remap offsets on windows without remap, which separates the two layout regions and the NUM_REMAP cut.

// File: rtl/awd_pkg.sv
package awd_pkg;

    // One decode window as held in the register bank
    typedef struct packed {
        logic        en;
        logic [3:0]  tgt;
        logic [7:0]  attr;
        logic [15:0] szm;      // (size-1) >> 16
        logic [15:0] base_lo;  // address bits 31:16
        logic [3:0]  base_hi;  // address bits 35:32
        logic [15:0] rmp_lo;   // remap bits 31:16
        logic [31:0] rmp_hi;
    } win_t;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_BASE = 2'd1,
        SEL_RLO  = 2'd2,
        SEL_RHI  = 2'd3
    } regsel_e;

    localparam int unsigned WIDE_WINS   = 8;      // windows with four words
    localparam int unsigned GAP_START   = 'h80;
    localparam int unsigned NARROW_BASE = 'h90;

endpackage

// File: rtl/awd_reg_map.sv
module awd_reg_map
    import awd_pkg::*;
#(
    parameter int unsigned NUM_WIN   = 20,
    parameter int unsigned NUM_REMAP = 8,
    parameter int unsigned REG_AW    = 12,
    localparam int unsigned IDX_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [REG_AW-1:0] addr,
    output logic              ok,
    output logic [IDX_W-1:0]  idx,
    output regsel_e           sel
);
    int unsigned a;
    int unsigned w;
    logic        placed;

    always_comb begin
        a      = 32'(addr);
        w      = 0;
        sel    = SEL_CTRL;
        placed = 1'b0;
        if (a < GAP_START) begin
            w      = a >> 4;
            sel    = regsel_e'(addr[3:2]);
            placed = 1'b1;
        end else if (a >= NARROW_BASE) begin
            w      = WIDE_WINS + ((a - NARROW_BASE) >> 3);
            sel    = addr[2] ? SEL_BASE : SEL_CTRL;
            placed = 1'b1;
        end
        ok = placed && (addr[1:0] == 2'b00) && (w < NUM_WIN) &&
             (((sel != SEL_RLO) && (sel != SEL_RHI)) || (w < NUM_REMAP));
        idx = IDX_W'(w);
    end
endmodule

// File: rtl/awd_match.sv
module awd_match
    import awd_pkg::*;
#(
    parameter int unsigned NUM_WIN   = 20,
    parameter int unsigned NUM_REMAP = 8
) (
    input  win_t [NUM_WIN-1:0] wins,
    input  logic [35:0]        addr,
    output logic [NUM_WIN-1:0] match,
    output logic [35:0]        xlat [NUM_WIN]
);
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign match[g] = wins[g].en &&
                          (wins[g].base_hi == addr[35:32]) &&
                          ((addr[31:16] & ~wins[g].szm) == wins[g].base_lo);
        if (g < NUM_REMAP) begin : g_rmp
            assign xlat[g] = {wins[g].rmp_hi[3:0],
                              (wins[g].rmp_lo & ~wins[g].szm) | (addr[31:16] & wins[g].szm),
                              addr[15:0]};
        end else begin : g_flat
            assign xlat[g] = addr;
        end
    end
endmodule

// File: rtl/awd_pick.sv
module awd_pick #(
    parameter int unsigned N = 20,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        gnt   = '0;
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt      = '0;
                gnt[i]   = 1'b1;
                found    = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int unsigned NUM_WIN   = 20,
    parameter int unsigned NUM_REMAP = 8,
    parameter int unsigned REG_AW    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lk_valid,
    input  logic [35:0]       lk_addr,
    output logic              lk_done,
    output logic              lk_hit,
    output logic              lk_decerr,
    output logic [3:0]        lk_target,
    output logic [7:0]        lk_attr,
    output logic [35:0]       lk_xaddr
);
    localparam int unsigned IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    typedef struct packed {
        win_t [NUM_WIN-1:0] win;
        logic [31:0]        rdata;
        logic               done;
        logic               hit;
        logic               decerr;
        logic [3:0]         tgt;
        logic [7:0]         attr;
        logic [35:0]        xaddr;
    } state_t;

    state_t s_d, s_q;

    logic              map_ok;
    logic [IDX_W-1:0]  map_idx;
    regsel_e           map_sel;
    logic [NUM_WIN-1:0] match_vec;
    logic [NUM_WIN-1:0] gnt_vec;
    logic [NUM_WIN-1:0] en_vec;
    logic [35:0]       xlat [NUM_WIN];
    logic              found;
    logic [IDX_W-1:0]  pick_idx;
    win_t              rd_win;

    awd_reg_map #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW)) map_i (
        .addr (reg_addr),
        .ok   (map_ok),
        .idx  (map_idx),
        .sel  (map_sel)
    );

    awd_match #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) match_i (
        .wins  (s_q.win),
        .addr  (lk_addr),
        .match (match_vec),
        .xlat  (xlat)
    );

    awd_pick #(.N(NUM_WIN)) pick_i (
        .req   (match_vec),
        .gnt   (gnt_vec),
        .found (found),
        .idx   (pick_idx)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_en
        assign en_vec[g] = s_q.win[g].en;
    end

    always_comb begin
        s_d    = s_q;
        rd_win = s_q.win[map_idx];

        // lookup result, one cycle after the request
        s_d.done   = lk_valid;
        s_d.hit    = lk_valid && found;
        s_d.decerr = lk_valid && !found;
        s_d.tgt    = '0;
        s_d.attr   = '0;
        s_d.xaddr  = '0;
        if (lk_valid) begin
            s_d.xaddr = lk_addr;
            if (found) begin
                s_d.tgt   = s_q.win[pick_idx].tgt;
                s_d.attr  = s_q.win[pick_idx].attr;
                s_d.xaddr = xlat[pick_idx];
            end
        end

        // register port
        if (reg_en && reg_we && map_ok) begin
            unique case (map_sel)
                SEL_CTRL: begin
                    s_d.win[map_idx].en   = reg_wdata[0];
                    s_d.win[map_idx].tgt  = reg_wdata[7:4];
                    s_d.win[map_idx].attr = reg_wdata[15:8];
                    s_d.win[map_idx].szm  = reg_wdata[31:16];
                end
                SEL_BASE: begin
                    s_d.win[map_idx].base_lo = reg_wdata[31:16];
                    s_d.win[map_idx].base_hi = reg_wdata[3:0];
                end
                SEL_RLO:  s_d.win[map_idx].rmp_lo = reg_wdata[31:16];
                SEL_RHI:  s_d.win[map_idx].rmp_hi = reg_wdata;
                default:  ;
            endcase
        end else if (reg_en && !reg_we) begin
            s_d.rdata = '0;
            if (map_ok) begin
                unique case (map_sel)
                    SEL_CTRL: s_d.rdata = {rd_win.szm, rd_win.attr, rd_win.tgt, 3'b000, rd_win.en};
                    SEL_BASE: s_d.rdata = {rd_win.base_lo, 12'h000, rd_win.base_hi};
                    SEL_RLO:  s_d.rdata = {rd_win.rmp_lo, 16'h0000};
                    SEL_RHI:  s_d.rdata = rd_win.rmp_hi;
                    default:  s_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_rdata = s_q.rdata;
    assign lk_done   = s_q.done;
    assign lk_hit    = s_q.hit;
    assign lk_decerr = s_q.decerr;
    assign lk_target = s_q.tgt;
    assign lk_attr   = s_q.attr;
    assign lk_xaddr  = s_q.xaddr;

endmodule

// File: rtl/awd_chk.sv
module awd_chk #(
    parameter int unsigned NUM_WIN = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_en,
    input logic               reg_we,
    input logic [31:0]        reg_rdata,
    input logic               lk_valid,
    input logic               lk_done,
    input logic               lk_hit,
    input logic               lk_decerr,
    input logic [NUM_WIN-1:0] match_vec,
    input logic [NUM_WIN-1:0] gnt_vec,
    input logic [NUM_WIN-1:0] en_vec
);
    // R7
    dis_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> ((match_vec & ~en_vec) == '0));

    // R8
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_vec));

    // R8
    gnt_in_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vec & ~match_vec) == '0);

    // R8
    gnt_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vec != '0) |-> (((gnt_vec - 1'b1) & match_vec) == '0));

    // R10
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!lk_done && !lk_hit && !lk_decerr));

    // R10
    hit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |-> (lk_hit != lk_decerr));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && !reg_we) |=> $stable(reg_rdata));
endmodule

bind addr_window_decoder awd_chk #(.NUM_WIN(NUM_WIN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .lk_valid  (lk_valid),
    .lk_done   (lk_done),
    .lk_hit    (lk_hit),
    .lk_decerr (lk_decerr),
    .match_vec (match_vec),
    .gnt_vec   (gnt_vec),
    .en_vec    (en_vec)
);

// File: tb/addr_window_decoder_tb_top.sv
`timescale 1ns/1ps
module addr_window_decoder_tb_top;
    localparam int NW = 20;
    localparam int NR = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [35:0] lk_addr = '0;
    logic        lk_done, lk_hit, lk_decerr;
    logic [3:0]  lk_target;
    logic [7:0]  lk_attr;
    logic [35:0] lk_xaddr;

    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;   // 125 MHz

    addr_window_decoder #(.NUM_WIN(NW), .NUM_REMAP(NR), .REG_AW(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_done(lk_done),
        .lk_hit(lk_hit), .lk_decerr(lk_decerr), .lk_target(lk_target),
        .lk_attr(lk_attr), .lk_xaddr(lk_xaddr)
    );

    // reference model of the window bank
    logic        m_en   [NW];
    logic [3:0]  m_tgt  [NW];
    logic [7:0]  m_attr [NW];
    logic [15:0] m_szm  [NW];
    logic [15:0] m_blo  [NW];
    logic [3:0]  m_bhi  [NW];
    logic [15:0] m_rlo  [NW];
    logic [31:0] m_rhi  [NW];

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic int woff(input int w, input int s);
        return (w < 8) ? (w * 16 + s * 4) : ('h90 + (w - 8) * 8 + s * 4);
    endfunction

    // R4/R5 decode: returns window or -1, and word kind
    function automatic int decode(input int a, output int s);
        int w;
        s = 0;
        if ((a % 4) != 0) return -1;
        if (a < 'h80) begin
            w = a / 16; s = (a / 4) % 4;
        end else if (a >= 'h90) begin
            w = 8 + (a - 'h90) / 8; s = (a / 4) % 2;
        end else return -1;
        if (w >= NW) return -1;
        if (s >= 2 && w >= NR) return -1;
        return w;
    endfunction

    function automatic logic [31:0] exp_rd(input int a);
        int s; int w;
        w = decode(a, s);
        if (w < 0) return 32'h0;
        case (s)
            0: return {m_szm[w], m_attr[w], m_tgt[w], 3'b000, m_en[w]};
            1: return {m_blo[w], 12'h000, m_bhi[w]};
            2: return {m_rlo[w], 16'h0000};
            default: return m_rhi[w];
        endcase
    endfunction

    task automatic model_wr(input int a, input logic [31:0] d);
        int s; int w;
        w = decode(a, s);
        if (w < 0) return;
        case (s)
            0: begin m_en[w] = d[0]; m_tgt[w] = d[7:4]; m_attr[w] = d[15:8]; m_szm[w] = d[31:16]; end
            1: begin m_blo[w] = d[31:16]; m_bhi[w] = d[3:0]; end
            2: m_rlo[w] = d[31:16];
            default: m_rhi[w] = d;
        endcase
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_en = 1; reg_we = 1; reg_addr = 12'(a); reg_wdata = d;
        @(negedge clk);
        reg_en = 0; reg_we = 0;
        model_wr(a, d);
    endtask

    task automatic rd_chk(input string tag, input int a);
        reg_en = 1; reg_we = 0; reg_addr = 12'(a);
        @(negedge clk);
        reg_en = 0;
        chk(tag, 64'(reg_rdata), 64'(exp_rd(a)));
    endtask

    task automatic lk_chk(input string tag, input logic [35:0] a);
        bit h; logic [3:0] t; logic [7:0] at; logic [35:0] x;
        h = 0; t = 0; at = 0; x = a;
        for (int w = 0; w < NW; w++) begin
            if (!h && m_en[w] && m_bhi[w] == a[35:32] &&
                ((a[31:16] & ~m_szm[w]) == m_blo[w])) begin
                h = 1; t = m_tgt[w]; at = m_attr[w];
                if (w < NR)
                    x = {m_rhi[w][3:0], (m_rlo[w] & ~m_szm[w]) | (a[31:16] & m_szm[w]), a[15:0]};
            end
        end
        lk_valid = 1; lk_addr = a;
        @(negedge clk);
        lk_valid = 0;
        chk({tag, " done/hit/err"}, {61'b0, lk_done, lk_hit, lk_decerr}, {61'b0, 1'b1, h, !h});
        chk({tag, " tgt/attr"}, {52'b0, lk_target, lk_attr}, {52'b0, t, at});
        chk({tag, " xaddr"}, 64'(lk_xaddr), 64'(x));
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd1234));
        for (int w = 0; w < NW; w++) begin
            m_en[w] = 0; m_tgt[w] = 0; m_attr[w] = 0; m_szm[w] = 0;
            m_blo[w] = 0; m_bhi[w] = 0; m_rlo[w] = 0; m_rhi[w] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        chk("R1 idle outputs", {61'b0, lk_done, lk_hit, lk_decerr}, 64'd0);
        rd_chk("R1 ctrl win0", woff(0, 0));
        rd_chk("R1 ctrl win19", woff(19, 0));
        lk_chk("R1 lookup zero", 36'h0_0000_0000);
        lk_chk("R1 lookup any", 36'h3_1234_5678);

        // R2: control layout, reserved bits 3:1 clear
        wr(woff(3, 0), 32'hABCD_12FE);
        rd_chk("R2 ctrl readback", woff(3, 0));
        chk("R2 ctrl literal", 64'(exp_rd(woff(3, 0))), 64'h0000_0000_ABCD_12F0);
        // R3: base layout
        wr(woff(3, 1), 32'h1234_FFFF);
        rd_chk("R3 base readback", woff(3, 1));
        chk("R3 base literal", 64'(exp_rd(woff(3, 1))), 64'h0000_0000_1234_000F);
        wr(woff(3, 0), 32'h0);
        wr(woff(3, 1), 32'h0);

        // R4: placement, gap, misalignment, out of range
        wr('h84, 32'hFFFF_FFFF);
        rd_chk("R4 gap read", 'h84);
        wr(woff(8, 0), 32'h0003_0141);
        rd_chk("R4 win8 ctrl", 'h90);
        wr(woff(9, 1), 32'h5555_0002);
        rd_chk("R4 win9 base", 'h9C);
        wr('h91, 32'hFFFF_FFF1);
        rd_chk("R4 misaligned write ignored", 'h90);
        rd_chk("R4 beyond last window", woff(NW, 0));
        wr(woff(7, 1), 32'h7777_0001);
        rd_chk("R4 win7 base", 'h74);
        wr(woff(8, 0), 32'h0); wr(woff(9, 1), 32'h0); wr(woff(7, 1), 32'h0);

        // R5: remap words
        wr(woff(2, 2), 32'hFFFF_FFFF);
        rd_chk("R5 remap-low low half", woff(2, 2));
        wr(woff(2, 3), 32'hDEAD_BEEF);
        rd_chk("R5 remap-high full", woff(2, 3));
        wr(woff(6, 2), 32'h1234_5678);
        rd_chk("R5 no remap on win6", woff(6, 2));
        chk("R5 win6 remap literal", 64'(exp_rd(woff(6, 2))), 64'd0);
        wr(woff(2, 2), 32'h0); wr(woff(2, 3), 32'h0);

        // R11: read data holds across a write
        rd_chk("R11 read", woff(2, 3));
        held = reg_rdata;
        wr(woff(2, 3), 32'h0000_0001);
        chk("R11 rdata held", 64'(reg_rdata), 64'(held));
        wr(woff(2, 3), 32'h0);

        // directed decode layout
        wr(woff(0, 1), 32'h1000_0000);           // win0 base 0x0_1000_0000
        wr(woff(0, 2), 32'h4000_0000);
        wr(woff(0, 3), 32'h0000_0001);
        wr(woff(0, 0), 32'h00FF_E041);           // mask 0xFF, attr E0, tgt 4, en
        wr(woff(1, 1), 32'h1000_0000);
        wr(woff(1, 0), 32'h0FFF_2F11);           // wider overlap, tgt 1
        wr(woff(10, 1), 32'h2000_0001);
        wr(woff(10, 0), 32'h0000_0131);          // 64 KB, tgt 3
        wr(woff(12, 1), 32'h3000_0000);
        wr(woff(12, 0), 32'h0000_0550);          // disabled
        // R8 + R9 remapped
        lk_chk("R8 overlap lowest", 36'h0_1012_3456);
        chk("R9 remap literal", 64'(lk_xaddr), 64'h1_4012_3456);
        lk_chk("R6 second window only", 36'h0_1100_0004);
        lk_chk("R9 pass-through", 36'h1_2000_ABCD);
        chk("R9 pass literal", 64'(lk_xaddr), 64'h1_2000_ABCD);
        lk_chk("R6 size edge miss", 36'h1_2001_0000);
        lk_chk("R7 disabled window", 36'h0_3000_0000);
        lk_chk("R6 upper base mismatch", 36'h1_1012_0000);
        lk_chk("R10 miss", 36'hF_FFFF_FFFF);
        wr(woff(0, 0), 32'h00FF_E040);           // disable win0
        lk_chk("R11 write visible next cycle", 36'h0_1012_3456);

        // random campaigns
        for (int round = 0; round < 25; round++) begin
            for (int w = 0; w < NW; w++) begin
                logic [15:0] sz; logic [31:0] c;
                case ($urandom_range(0, 3))
                    0: sz = 16'h0000;
                    1: sz = 16'h000F;
                    2: sz = 16'h00FF;
                    default: sz = 16'($urandom) >> $urandom_range(4, 15);
                endcase
                c = {sz, 8'($urandom), 4'($urandom), 3'($urandom), 1'($urandom_range(0, 3) != 0)};
                wr(woff(w, 1), {16'($urandom) & ~sz, 12'($urandom), 4'($urandom_range(0, 1))});
                wr(woff(w, 0), c);
                if (w < 8) begin
                    wr(woff(w, 2), $urandom);
                    wr(woff(w, 3), $urandom);
                end
            end
            for (int k = 0; k < 4; k++) begin
                int a;
                a = $urandom_range(0, 'hFF) & 'hFFC;
                if ($urandom_range(0, 5) == 0) a = a | $urandom_range(1, 3);
                rd_chk("R4 R5 random read", a);
            end
            for (int k = 0; k < 30; k++) begin
                int j; logic [35:0] a;
                j = $urandom_range(0, NW - 1);
                a = {m_bhi[j], m_blo[j] | (16'($urandom) & m_szm[j]), 16'($urandom)};
                if ($urandom_range(0, 4) == 0) a = {4'($urandom), 32'($urandom)};
                lk_chk("R6 R8 R9 random lookup", a);
            end
        end

        finish_run();
    end
endmodule